// File: doc/BRIEF.md
# Cascaded Two-Stage Interval Timer

This peripheral keeps time for a small controller. It chains two 8-bit counters. The first stage always advances on the slow auxiliary clock. The second stage advances on a clock picked in the control register: the auxiliary clock, the auxiliary clock divided by 256 (the carry out of the first stage), or the main clock. One bit of the second counter, picked by a 3-bit code, raises a sticky interrupt flag each time it rises. That gives an interval of 2 to 256 periods of the second-stage clock. One bit of the first counter, picked by a 2-bit code, produces a one-cycle strobe for an LCD frame clock. The strobe divides the auxiliary clock by 32, 64, 128 or 256.

Everything runs on one system clock. The auxiliary and main clocks arrive as one-cycle enable ticks on that clock. Software reaches the block through a byte-wide register port. The control byte is read/write. The two counts are read-only. Writes to the count addresses are dropped. A hold-clear bit in the control byte freezes the first stage at zero and keeps the flag cleared. If the divide bit is also set, it freezes the second stage at zero as well.

Top module: `ivt_timer`

## Requirements
- R1: After reset the control byte and both counts read as zero, and `irq_flag` and `lcd_strobe` are low.
- R2: A write to address 0x40 loads the control byte, which reads back and takes effect from the next cycle. Writes to 0x46 and 0x47 change nothing.
- R3: Address 0x46 reads the first count and 0x47 reads the second count, combinationally. Any other address except 0x40 reads zero.
- R4: While the hold-clear bit (bit 6) is 0, the first count rises by one on each `aux_tick` and wraps from 255 to 0.
- R5: The second count rises by one on each tick of the selected source. Bit 7 = 1 selects `main_tick`. Bit 7 = 0 with bit 5 = 0 selects `aux_tick`. Bit 7 = 0 with bit 5 = 1 selects the first stage wrapping from 255 to 0.
- R6: `irq_flag` is set in the cycle after an increment changes bit n of the second count from 0 to 1, where n is control bits 2:0. This gives an interval of 2^(n+1) second-stage ticks.
- R7: Once set, `irq_flag` stays high until a `flag_clr` pulse clears it. A set event in the same cycle as `flag_clr` wins.
- R8: While bit 6 is 1, the first count is held at zero and `irq_flag` is held low. If bit 5 is also 1, the second count is held at zero too. Otherwise the second count keeps counting.
- R9: `lcd_strobe` pulses for one cycle in the cycle after an increment changes bit (m+4) of the first count from 0 to 1, where m is control bits 4:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_tick | input | 1 | One-cycle enable, auxiliary clock |
| main_tick | input | 1 | One-cycle enable, main clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| lcd_strobe | output | 1 | One-cycle LCD frame pulse |

## Verification
The assertions assume each tick input is a clean one-cycle enable. They also assume that register writes and `flag_clr` change only between clock edges. The step checks assume the counts move only through the documented increments.

The stimulus drives every input at the falling edge. Ticks follow fixed modulo patterns, including a tick on every cycle so the first stage wraps. Writes to the count addresses and `flag_clr` pulses are interleaved so that they land on cycles where a count changes or the flag sets.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    localparam int unsigned BYTE_W = 8;

    // Control byte layout; bit positions are decoded by the counter stages.
    typedef struct packed {
        logic       src_main;  // bit 7: second stage from main tick
        logic       hold_clr;  // bit 6: hold/clear counters and flag
        logic       div_sel;   // bit 5: second stage from first-stage carry
        logic [1:0] lcd_code;  // bits 4:3: strobe tap select
        logic [2:0] ivl_code;  // bits 2:0: interrupt tap select
    } ivt_ctrl_t;

    typedef enum logic [1:0] {
        SRC_AUX     = 2'd0,
        SRC_AUX_DIV = 2'd1,
        SRC_MAIN    = 2'd2
    } ivt_src_e;

    function automatic ivt_src_e decode_src(input logic src_main, input logic div_sel);
        if (src_main)     return SRC_MAIN;
        else if (div_sel) return SRC_AUX_DIV;
        else              return SRC_AUX;
    endfunction

endpackage

// File: rtl/ivt_regs.sv
`timescale 1ns/1ps
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned CTRL_ADDR = 'h40,
    parameter int unsigned CNT1_ADDR = 'h46,
    parameter int unsigned CNT2_ADDR = 'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt1,
    input  logic [CNT_W-1:0]  cnt2,
    output ivt_ctrl_t         ctrl,
    output logic [BYTE_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] CNT1_A = ADDR_W'(CNT1_ADDR);
    localparam logic [ADDR_W-1:0] CNT2_A = ADDR_W'(CNT2_ADDR);

    typedef struct packed {
        ivt_ctrl_t ctrl;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (addr == CTRL_A)) begin
            st_d.ctrl = ivt_ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A)      rdata = BYTE_W'(st_q.ctrl);
        else if (addr == CNT1_A) rdata = BYTE_W'(cnt1);
        else if (addr == CNT2_A) rdata = BYTE_W'(cnt2);
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_A) |=> (BYTE_W'(ctrl) == $past(wdata))) // R2
        else $error("control load mismatch");

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == CTRL_A) |=> $stable(ctrl)) // R2
        else $error("control changed without write");

endmodule

// File: rtl/ivt_stage1.sv
`timescale 1ns/1ps
module ivt_stage1 #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned LCD_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_tick,
    input  logic              hold,
    input  logic [CODE_W-1:0] lcd_code,
    output logic [CNT_W-1:0]  cnt,
    output logic              carry,
    output logic              strobe
);

    localparam int unsigned IDX_W = $clog2(CNT_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } s1_st_t;

    s1_st_t           st_d, st_q;
    logic             step;
    logic [CNT_W-1:0] nxt;
    logic [IDX_W-1:0] tap;

    always_comb begin
        step  = aux_tick && !hold;
        nxt   = st_q.cnt + 1'b1;
        tap   = IDX_W'(LCD_BASE) + IDX_W'(lcd_code);
        carry = step && (st_q.cnt == '1);

        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
        end else if (aux_tick) begin
            st_d.cnt = nxt;
        end
        if (step && !st_q.cnt[tap] && nxt[tap]) begin
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign strobe = st_q.strobe;

    AST_C1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_tick && !hold) |=> (cnt == $past(cnt) + 1'b1)) // R4
        else $error("first stage step wrong");

    AST_C1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0)) // R8
        else $error("first stage not held");

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe) // R9
        else $error("strobe wider than one cycle");

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> ($past(aux_tick) && !$past(hold))) // R9
        else $error("strobe without tick");

endmodule

// File: rtl/ivt_stage2.sv
`timescale 1ns/1ps
module ivt_stage2
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_tick,
    input  logic              main_tick,
    input  logic              carry_in,
    input  logic              src_main,
    input  logic              div_sel,
    input  logic              hold,
    input  logic [CODE_W-1:0] ivl_code,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag
);

    localparam int unsigned IDX_W = $clog2(CNT_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } s2_st_t;

    s2_st_t           st_d, st_q;
    ivt_src_e         src;
    logic             tick;
    logic             zap;
    logic             rise;
    logic [CNT_W-1:0] nxt;
    logic [IDX_W-1:0] tap;

    always_comb begin
        src = decode_src(src_main, div_sel);
        unique case (src)
            SRC_MAIN:    tick = main_tick;
            SRC_AUX_DIV: tick = carry_in;
            default:     tick = aux_tick;
        endcase
        zap  = hold && div_sel;
        nxt  = st_q.cnt + 1'b1;
        tap  = IDX_W'(ivl_code);
        rise = tick && !zap && !st_q.cnt[tap] && nxt[tap];

        st_d = st_q;
        if (zap)       st_d.cnt = '0;
        else if (tick) st_d.cnt = nxt;

        if (hold)          st_d.flag = 1'b0;
        else if (rise)     st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

    AST_C2_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && div_sel) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)) // R5
        else $error("second stage jumped");

    AST_C2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && div_sel) |=> (cnt == '0)) // R8
        else $error("second stage not held");

    AST_FLAG_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !flag) // R8
        else $error("flag set during hold");

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr && !hold) |=> flag) // R7
        else $error("flag dropped without clear");

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) != cnt)) // R6
        else $error("flag rose without count step");

endmodule

// File: rtl/ivt_timer.sv
`timescale 1ns/1ps
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned LCD_BASE  = 4,
    parameter int unsigned CTRL_ADDR = 'h40,
    parameter int unsigned CNT1_ADDR = 'h46,
    parameter int unsigned CNT2_ADDR = 'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_tick,
    input  logic              main_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic              lcd_strobe
);

    localparam int unsigned LCD_CW = 2;
    localparam int unsigned IVL_CW = 3;

    ivt_ctrl_t        ctrl;
    logic [CNT_W-1:0] cnt1;
    logic [CNT_W-1:0] cnt2;
    logic             carry1;

    ivt_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .CTRL_ADDR(CTRL_ADDR), .CNT1_ADDR(CNT1_ADDR), .CNT2_ADDR(CNT2_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cnt1(cnt1), .cnt2(cnt2),
        .ctrl(ctrl), .rdata(reg_rdata)
    );

    ivt_stage1 #(
        .CNT_W(CNT_W), .CODE_W(LCD_CW), .LCD_BASE(LCD_BASE)
    ) u_stage1 (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .hold(ctrl.hold_clr),
        .lcd_code(ctrl.lcd_code), .cnt(cnt1), .carry(carry1), .strobe(lcd_strobe)
    );

    ivt_stage2 #(
        .CNT_W(CNT_W), .CODE_W(IVL_CW)
    ) u_stage2 (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .main_tick(main_tick),
        .carry_in(carry1), .src_main(ctrl.src_main), .div_sel(ctrl.div_sel),
        .hold(ctrl.hold_clr), .ivl_code(ctrl.ivl_code), .flag_clr(flag_clr),
        .cnt(cnt2), .flag(irq_flag)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_flag && !lcd_strobe)) // R1
        else $error("outputs active after reset");

endmodule

// File: tb/ivt_timer_test.sv
`timescale 1ns/1ps
module ivt_timer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       aux_tick, main_tick, reg_wr, flag_clr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       irq_flag, lcd_strobe;

    always #2.5 clk = ~clk;

    ivt_timer uut (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .main_tick(main_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flag_clr(flag_clr),
        .irq_flag(irq_flag), .lcd_strobe(lcd_strobe)
    );

    typedef struct {
        logic flag;
        logic strobe;
    } exp_t;

    exp_t       sb_q[$];
    int         n_tests = 0;
    int         n_fail  = 0;
    logic [7:0] m_ctrl  = '0;
    logic [7:0] m_c1    = '0;
    logic [7:0] m_c2    = '0;
    logic       m_flag  = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R6/R7", "irq_flag", {7'd0, irq_flag}, {7'd0, e.flag});
                check("R9", "lcd_strobe", {7'd0, lcd_strobe}, {7'd0, e.strobe});
            end
        end
    end

    // Driver: one cycle of stimulus, optional read check, model update, push.
    task automatic step(input logic a, input logic m, input logic wr,
                        input logic [7:0] addr, input logic [7:0] wd, input logic clr);
        logic       hold, dv, sm, ovf, t2, zap, rise, strb;
        logic [7:0] c1n, c2n;
        int         lt, it;
        exp_t       e;
        @(negedge clk);
        aux_tick = a; main_tick = m; reg_wr = wr;
        reg_addr = addr; reg_wdata = wd; flag_clr = clr;
        #1;
        case (addr)
            8'h40:   check("R2", "ctrl read", reg_rdata, m_ctrl);
            8'h46:   check("R3", "cnt1 read", reg_rdata, m_c1);
            8'h47:   check("R3", "cnt2 read", reg_rdata, m_c2);
            default: check("R3", "other read", reg_rdata, 8'h00);
        endcase
        hold = m_ctrl[6]; dv = m_ctrl[5]; sm = m_ctrl[7];
        c1n  = m_c1 + 8'd1;
        lt   = 4 + int'(m_ctrl[4:3]);
        strb = !hold && a && !m_c1[lt] && c1n[lt];
        ovf  = !hold && a && (m_c1 == 8'hFF);
        t2   = sm ? m : (dv ? ovf : a);
        zap  = hold && dv;
        c2n  = m_c2 + 8'd1;
        it   = int'(m_ctrl[2:0]);
        rise = !zap && t2 && !m_c2[it] && c2n[it];
        m_c1 = hold ? 8'd0 : (a ? c1n : m_c1);
        m_c2 = zap ? 8'd0 : (t2 ? c2n : m_c2);
        if (hold)      m_flag = 1'b0;
        else if (rise) m_flag = 1'b1;
        else if (clr)  m_flag = 1'b0;
        if (wr && addr == 8'h40) m_ctrl = wd;
        e.flag = m_flag; e.strobe = strb;
        sb_q.push_back(e);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        step(1'b0, 1'b0, 1'b1, 8'h40, v, 1'b0);
    endtask

    task automatic run(input int n, input int amod, input int mmod, input int cmod);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ad;
            logic       w;
            case (i % 4)
                0: ad = 8'h46;
                1: ad = 8'h47;
                2: ad = 8'h40;
                default: ad = 8'h41;
            endcase
            w = ((i % 13) == 5);
            if (w) ad = ((i % 2) == 0) ? 8'h46 : 8'h47;   // R2: ignored writes
            step((i % amod) == 0, (mmod > 0) && ((i % mmod) == 0), w, ad,
                 8'hA5, (cmod > 0) && ((i % cmod) == 3));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; aux_tick = 0; main_tick = 0; reg_wr = 0;
        reg_addr = 8'h40; reg_wdata = 0; flag_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "ctrl after reset", reg_rdata, 8'h00);
        reg_addr = 8'h46; #1;
        check("R1", "cnt1 after reset", reg_rdata, 8'h00);
        reg_addr = 8'h47; #1;
        check("R1", "cnt2 after reset", reg_rdata, 8'h00);
        check("R1", "flags after reset", {6'd0, irq_flag, lcd_strobe}, 8'h00);

        // R4 R5 R6 R9: aux source, interval code 0, strobe /32
        run(300, 2, 0, 7);
        // R5 R9: carry source, strobe /256, interval code 0
        wr_ctrl(8'h38);
        run(700, 1, 0, 0);
        // R5 R7: main source, interval code 2, clears colliding with sets
        wr_ctrl(8'h82);
        run(200, 3, 2, 4);
        // R8: hold without divide, stage 2 keeps counting
        wr_ctrl(8'h40);
        run(60, 1, 0, 0);
        // R8: hold with divide, both counts held
        wr_ctrl(8'h60);
        run(40, 1, 1, 0);
        // R6: interval code 7 on aux source, strobe /64
        wr_ctrl(8'h0F);
        run(600, 1, 0, 0);
        // R6: interval code 3, strobe /128, clears
        wr_ctrl(8'h13);
        run(200, 1, 0, 11);

        repeat (3) @(posedge clk);
        #2;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule